// File: doc/BRIEF.md
# Slot-Timed Power Sequencer

This block orders the switching of a set of power-related outputs (regulator enables, general-purpose output enables and a slow clock gate) in time. Three shared slot timers each watch one selectable enable: either of two hardware enable pins or a software bit. A rising or falling edge on that enable starts a run of eight slot events, evenly spaced by a programmable interval. The interval is counted in pulses of a 1 MHz tick input.

Each output channel either follows its own software bit or is tied to one of the three timers. A tied channel switches on when the timer's power-up run reaches the channel's up slot. When the power-down run reaches the channel's down slot, the channel does one of three things, chosen per channel: it switches off, it asserts a low-power flag, or it holds its state. Configuration is written through a small write-only register port. Each timer shows a busy flag while its run is in progress and a one-cycle done pulse after its last slot.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset, every `ch_on`, `ch_lpm`, `tmr_busy` and `tmr_done` bit is 0, and every register is 0.
- R2: Timer register at address t (0..2) holds: bits [1:0] enable source, bits [4:2] interval code, bit [5] software enable. Source codes are 0 = none (enable held low), 1 = `en_pin_a`, 2 = `en_pin_b`, 3 = software enable. A pin that is not selected has no effect on that timer.
- R3: Let S be the first clock edge at which a timer sees a changed enable level. Slot k (0..7) of the run occurs at edge S+(k+1)·N, where N = 40·2^code ticks. With `tick` held high, a tied channel whose up slot is k rises at edge S+(k+1)·N+1.
- R4: Slot timing advances only on clock edges where `tick` is 1. A run with `tick` low stays busy and emits no slot.
- R5: Channel register at address 8+c holds: bits [1:0] source (0 = software, 1..3 = timer 0..2), bits [4:2] up slot, bits [7:5] down slot, bits [9:8] down response, bit [10] software bit. At the down slot of a falling run, the response is applied: 1 clears `ch_on`, 2 sets `ch_lpm` while leaving `ch_on` at 1, and 0 or 3 leave the channel unchanged. `ch_lpm` is never 1 while `ch_on` is 0.
- R6: Reaching the up slot of a rising run clears `ch_lpm`.
- R7: A channel with source 0 drives `ch_on` equal to its software bit one clock after the register write, keeps `ch_lpm` at 0, and ignores all slot events.
- R8: `tmr_busy` is 1 from edge S until edge S+8·N. `tmr_done` is 1 for exactly the one cycle that follows edge S+8·N+1.
- R9: An enable edge during a run restarts the timer at once from slot 0 in the new direction. Channels that already switched keep their state until a later slot of the new run changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1 MHz timebase pulse, one clock wide |
| en_pin_a | input | 1 | First hardware enable pin |
| en_pin_b | input | 1 | Second hardware enable pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 11 | Register write data |
| ch_on | output | NUM_CH | Channel enable outputs |
| ch_lpm | output | NUM_CH | Channel low-power flags |
| tmr_busy | output | 3 | Timer run in progress |
| tmr_done | output | 3 | Timer run finished, one-cycle pulse |

## Verification
A table of slot setups is run, each with a different up slot, down slot, down response and interval code. Sampling just before and just after the predicted edge checks the doubling of the interval and the exact slot count, and shows whether each response switches off, flags low power or holds. Directed sequences follow. Stalling `tick` separates tick-gated counting from free-running counting. Raising the pin that is not selected, and raising a pin under source code none, checks the source decoding. A software-owned channel runs next to a live timer to show that slot events leave it alone. An enable reversal in the middle of a run shows the restart and the state kept by a channel that had already switched.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int NUM_TMR  = 3;
  localparam int NUM_SLOT = 8;

  typedef enum logic [1:0] {
    TSRC_NONE  = 2'd0,
    TSRC_PIN_A = 2'd1,
    TSRC_PIN_B = 2'd2,
    TSRC_SOFT  = 2'd3
  } tsrc_e;

  typedef enum logic [1:0] {
    DRESP_HOLD  = 2'd0,
    DRESP_OFF   = 2'd1,
    DRESP_LPM   = 2'd2,
    DRESP_HOLD2 = 2'd3
  } dresp_e;

  typedef struct packed {
    logic       soft_en;
    logic [2:0] per_code;
    tsrc_e      src;
  } tmr_cfg_t;

  typedef struct packed {
    logic       soft_on;
    dresp_e     resp;
    logic [2:0] dn_slot;
    logic [2:0] up_slot;
    logic [1:0] src;
  } ch_cfg_t;

  // Slot interval in ticks: base doubled once per code step.
  function automatic int unsigned period_ticks(input logic [2:0] code,
                                               input int unsigned base);
    return base << code;
  endfunction
endpackage

// File: rtl/pwrseq_regs.sv
module pwrseq_regs
  import pwrseq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = $bits(ch_cfg_t)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output tmr_cfg_t          tmr_cfg [NUM_TMR],
  output ch_cfg_t           ch_cfg  [NUM_CH]
);
  localparam int CH_BASE = 8;
  localparam int TW      = $bits(tmr_cfg_t);

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    always_ff @(posedge clk) begin
      if (!rst_n)
        tmr_cfg[t] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(t))
        tmr_cfg[t] <= tmr_cfg_t'(wr_data[TW-1:0]);
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)
        ch_cfg[c] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(CH_BASE + c))
        ch_cfg[c] <= ch_cfg_t'(wr_data);
    end
  end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer
  import pwrseq_pkg::*;
#(
  parameter int BASE_TICKS = 40,
  parameter int CNT_W      = $clog2((BASE_TICKS << 7) + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en_lvl,
  input  logic [2:0] per_code,
  output logic       slot_evt,
  output logic [2:0] slot_idx,
  output logic       slot_dir,
  output logic       busy,
  output logic       done
);
  logic             en_q;
  logic [CNT_W-1:0] tcnt;
  logic [2:0]       scnt;
  logic [CNT_W-1:0] lim;
  logic             edge_seen;

  assign edge_seen = en_lvl ^ en_q;
  assign lim       = CNT_W'(period_ticks(per_code, BASE_TICKS) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      tcnt     <= '0;
      scnt     <= '0;
      slot_evt <= 1'b0;
      slot_idx <= '0;
      slot_dir <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      en_q     <= en_lvl;
      slot_evt <= 1'b0;
      done     <= slot_evt && (slot_idx == 3'(NUM_SLOT - 1));
      if (edge_seen) begin
        busy     <= 1'b1;
        slot_dir <= en_lvl;
        tcnt     <= '0;
        scnt     <= '0;
      end else if (busy && tick) begin
        if (tcnt >= lim) begin
          tcnt     <= '0;
          slot_evt <= 1'b1;
          slot_idx <= scnt;
          scnt     <= scnt + 3'd1;
          if (scnt == 3'(NUM_SLOT - 1))
            busy <= 1'b0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwrseq_chan.sv
module pwrseq_chan
  import pwrseq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  ch_cfg_t                    cfg,
  input  logic [NUM_TMR-1:0]         evt,
  input  logic [NUM_TMR-1:0][2:0]    idx,
  input  logic [NUM_TMR-1:0]         dir,
  output logic                       on,
  output logic                       lpm
);
  logic       soft_mode;
  logic [1:0] sel;
  logic       hit_up;
  logic       hit_dn;

  always_comb begin
    soft_mode = (cfg.src == 2'd0);
    sel       = soft_mode ? 2'd0 : cfg.src - 2'd1;
    hit_up    = !soft_mode && evt[sel] &&  dir[sel] && idx[sel] == cfg.up_slot;
    hit_dn    = !soft_mode && evt[sel] && !dir[sel] && idx[sel] == cfg.dn_slot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on  <= 1'b0;
      lpm <= 1'b0;
    end else if (soft_mode) begin
      on  <= cfg.soft_on;
      lpm <= 1'b0;
    end else if (hit_up) begin
      on  <= 1'b1;
      lpm <= 1'b0;
    end else if (hit_dn) begin
      case (cfg.resp)
        DRESP_OFF: begin
          on  <= 1'b0;
          lpm <= 1'b0;
        end
        DRESP_LPM: lpm <= on;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int BASE_TICKS = 40,
  parameter int ADDR_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      en_pin_a,
  input  logic                      en_pin_b,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [$bits(ch_cfg_t)-1:0] wr_data,
  output logic [NUM_CH-1:0]         ch_on,
  output logic [NUM_CH-1:0]         ch_lpm,
  output logic [NUM_TMR-1:0]        tmr_busy,
  output logic [NUM_TMR-1:0]        tmr_done
);
  tmr_cfg_t                  tmr_cfg [NUM_TMR];
  ch_cfg_t                   ch_cfg  [NUM_CH];
  logic [NUM_TMR-1:0]        t_en;
  logic [NUM_TMR-1:0]        t_evt;
  logic [NUM_TMR-1:0][2:0]   t_idx;
  logic [NUM_TMR-1:0]        t_dir;
  logic [NUM_CH-1:0]         ch_softmode;
  logic [NUM_CH-1:0]         ch_softbit;

  pwrseq_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tmr_cfg(tmr_cfg), .ch_cfg(ch_cfg)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    always_comb begin
      case (tmr_cfg[t].src)
        TSRC_PIN_A: t_en[t] = en_pin_a;
        TSRC_PIN_B: t_en[t] = en_pin_b;
        TSRC_SOFT:  t_en[t] = tmr_cfg[t].soft_en;
        default:    t_en[t] = 1'b0;
      endcase
    end

    pwrseq_timer #(.BASE_TICKS(BASE_TICKS)) tmr_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en_lvl(t_en[t]),
      .per_code(tmr_cfg[t].per_code), .slot_evt(t_evt[t]),
      .slot_idx(t_idx[t]), .slot_dir(t_dir[t]),
      .busy(tmr_busy[t]), .done(tmr_done[t])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_softmode[c] = (ch_cfg[c].src == 2'd0);
    assign ch_softbit[c]  = ch_cfg[c].soft_on;

    pwrseq_chan chan_i (
      .clk(clk), .rst_n(rst_n), .cfg(ch_cfg[c]), .evt(t_evt),
      .idx(t_idx), .dir(t_dir), .on(ch_on[c]), .lpm(ch_lpm[c])
    );
  end
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk
  import pwrseq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick,
  input logic [NUM_TMR-1:0]      t_evt,
  input logic [NUM_TMR-1:0][2:0] t_idx,
  input logic [NUM_TMR-1:0]      t_busy,
  input logic [NUM_TMR-1:0]      t_done,
  input logic [NUM_CH-1:0]       ch_on,
  input logic [NUM_CH-1:0]       ch_lpm,
  input logic [NUM_CH-1:0]       ch_softmode,
  input logic [NUM_CH-1:0]       ch_softbit
);
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
    AST_EVT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      t_evt[t] |-> $past(tick)); // R4
    AST_EVT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      t_evt[t] |-> $past(t_busy[t])); // R3
    AST_LAST_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (t_evt[t] && t_idx[t] == 3'd7) |-> !t_busy[t]); // R8
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      t_done[t] |-> $past(t_evt[t] && t_idx[t] == 3'd7)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      t_done[t] |=> !t_done[t]); // R8
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    AST_LPM_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      ch_lpm[c] |-> ch_on[c]); // R5
    AST_SOFT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ch_softmode[c]) |-> ch_on[c] == $past(ch_softbit[c])); // R7
    AST_SOFT_NO_LPM: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ch_softmode[c]) |-> !ch_lpm[c]); // R7
  end
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .t_evt(t_evt), .t_idx(t_idx),
  .t_busy(tmr_busy), .t_done(tmr_done), .ch_on(ch_on), .ch_lpm(ch_lpm),
  .ch_softmode(ch_softmode), .ch_softbit(ch_softbit)
);

// File: tb/pwrseq_ctrl_tb_top.sv
module pwrseq_ctrl_tb_top;
  localparam int NCH  = 8;
  localparam int BASE = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        en_pin_a = 1'b0;
  logic        en_pin_b = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [10:0] wr_data = '0;
  logic [NCH-1:0] ch_on, ch_lpm;
  logic [2:0]  tmr_busy, tmr_done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pwrseq_ctrl #(.NUM_CH(NCH), .BASE_TICKS(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en_pin_a(en_pin_a),
    .en_pin_b(en_pin_b), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ch_on(ch_on), .ch_lpm(ch_lpm),
    .tmr_busy(tmr_busy), .tmr_done(tmr_done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail);
      $finish;
    end
  end

  typedef struct packed {
    logic [2:0] up;
    logic [2:0] dn;
    logic [1:0] resp;
    logic [2:0] per;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{up: 3'd0, dn: 3'd2, resp: 2'd1, per: 3'd0},
    '{up: 3'd3, dn: 3'd0, resp: 2'd2, per: 3'd0},
    '{up: 3'd7, dn: 3'd5, resp: 2'd0, per: 3'd1},
    '{up: 3'd1, dn: 3'd7, resp: 2'd1, per: 3'd1}
  };

  function automatic logic [10:0] tmd(input int src, input int per, input int sw);
    return 11'((sw << 5) | (per << 2) | src);
  endfunction

  function automatic logic [10:0] chd(input int src, input int up, input int dn,
                                      input int resp, input int sw);
    return 11'((sw << 10) | (resp << 8) | (dn << 5) | (up << 2) | src);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [10:0] data);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 4'(addr);
    wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick = 1'b1;
    en_pin_a = 1'b0;
    en_pin_b = 1'b0;
    wr_en = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 ch_on", int'(ch_on), 0);
    chk("R1 ch_lpm", int'(ch_lpm), 0);
    chk("R1 busy", int'(tmr_busy), 0);
    chk("R1 done", int'(tmr_done), 0);

    // Table walk: R3 slot timing, R5 down response
    for (int v = 0; v < 4; v++) begin
      int n, eon, elpm;
      n = BASE << VECS[v].per;
      do_reset();
      wr(10, chd(1, VECS[v].up, VECS[v].dn, VECS[v].resp, 0));
      wr(0, tmd(3, VECS[v].per, 1));
      step((VECS[v].up + 1) * n + 1);
      chk("R3 before up slot", ch_on[2], 0);
      step(1);
      chk("R3 at up slot", ch_on[2], 1);
      step(8 * n);
      wr(0, tmd(3, VECS[v].per, 0));
      step((VECS[v].dn + 1) * n + 1);
      chk("R5 before down slot", ch_on[2], 1);
      step(1);
      eon  = (VECS[v].resp == 2'd1) ? 0 : 1;
      elpm = (VECS[v].resp == 2'd2) ? 1 : 0;
      chk("R5 on after down slot", ch_on[2], eon);
      chk("R5 lpm after down slot", ch_lpm[2], elpm);
    end

    // R8 busy and done timing
    do_reset();
    wr(0, tmd(3, 0, 1));
    step(1);
    chk("R8 busy at start", tmr_busy[0], 1);
    step(8 * BASE - 1);
    chk("R8 busy before last", tmr_busy[0], 1);
    chk("R8 no early done", tmr_done[0], 0);
    step(1);
    chk("R8 idle after last", tmr_busy[0], 0);
    step(1);
    chk("R8 done pulse", tmr_done[0], 1);
    step(1);
    chk("R8 done one cycle", tmr_done[0], 0);

    // R4 tick gating
    do_reset();
    wr(8, chd(1, 0, 0, 1, 0));
    tick = 1'b0;
    wr(0, tmd(3, 0, 1));
    step(200);
    chk("R4 stalled channel", ch_on[0], 0);
    chk("R4 stalled busy", tmr_busy[0], 1);
    tick = 1'b1;
    step(BASE);
    chk("R4 before slot", ch_on[0], 0);
    step(1);
    chk("R4 slot after ticks", ch_on[0], 1);

    // R2 source selection
    do_reset();
    wr(1, tmd(2, 0, 0));
    wr(9, chd(2, 0, 0, 1, 0));
    wr(15, chd(3, 0, 0, 1, 0));
    en_pin_a = 1'b1;
    step(100);
    chk("R2 unselected pin ignored", ch_on[1], 0);
    chk("R2 source none ignores pins", ch_on[7], 0);
    en_pin_b = 1'b1;
    step(BASE + 1);
    chk("R2 pin b before slot", ch_on[1], 0);
    step(1);
    chk("R2 pin b starts timer", ch_on[1], 1);
    chk("R2 source none stays off", ch_on[7], 0);

    // R7 software channel
    do_reset();
    wr(11, chd(0, 0, 0, 0, 1));
    chk("R7 not yet", ch_on[3], 0);
    step(1);
    chk("R7 follows bit", ch_on[3], 1);
    wr(11, chd(0, 0, 0, 0, 0));
    step(1);
    chk("R7 follows clear", ch_on[3], 0);
    wr(0, tmd(3, 0, 1));
    step(8 * BASE + 3);
    chk("R7 ignores slots", ch_on[3], 0);

    // R9 restart mid-run
    do_reset();
    wr(12, chd(1, 1, 7, 1, 0));
    wr(13, chd(1, 6, 7, 1, 0));
    wr(0, tmd(3, 0, 1));
    step(3 * BASE);
    chk("R9 early channel on", ch_on[4], 1);
    chk("R9 late channel off", ch_on[5], 0);
    wr(0, tmd(3, 0, 0));
    step(4 * BASE);
    chk("R9 passed channel kept", ch_on[4], 1);
    chk("R9 late channel never on", ch_on[5], 0);
    chk("R9 restarted busy", tmr_busy[0], 1);
    step(4 * BASE + 3);
    chk("R9 down run completes", ch_on[4], 0);
    chk("R9 late channel still off", ch_on[5], 0);

    // R6 power-up clears low-power flag
    do_reset();
    wr(14, chd(1, 2, 0, 2, 0));
    wr(0, tmd(3, 0, 1));
    step(8 * BASE + 4);
    wr(0, tmd(3, 0, 0));
    step(8 * BASE + 4);
    chk("R6 lpm set", ch_lpm[6], 1);
    chk("R6 on kept", ch_on[6], 1);
    wr(0, tmd(3, 0, 1));
    step(3 * BASE + 1);
    chk("R6 lpm before up slot", ch_lpm[6], 1);
    step(1);
    chk("R6 lpm cleared at up slot", ch_lpm[6], 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule